// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block is the status-register stage that a processor core uses when it leaves an exception handler. During normal operation it registers the core's current status word and stack pointer unchanged. When the return strobe is raised, it removes the most recent level of saved mode bits from the status word. The two highest bits are kept in place. The low 28-bit field moves down by ten positions, so the saved copy of the mode and flag bits becomes the live copy.

After the shift, the block applies a rule to the store-permission flag. That flag is forced on when the retry flag was clear in the status word before the return. If the restored status selects user mode, the stack pointer is exchanged: the current pointer is saved as the kernel copy, and the user pointer becomes the live pointer.

The block also answers conditional-store requests. A request fails while the store-permission flag of the status presented in that cycle is set. Every output is a register and updates on the clock edge after the inputs that cause the change.

Top module: `exc_return_shifter`

## Requirements
- R1: While reset is asserted, and until the first update after it, `status_o`, `sp_o`, `ksp_o` and `store_fail_o` are all zero.
- R2: In a cycle with `ret_i` low, the next edge loads `status_o` with `status_i` and `sp_o` with `sp_i`.
- R3: In a cycle with `ret_i` high, the next `status_o` is formed as follows, apart from bit 7 (see R4):
  - bits [31:30] are copied from `status_i`;
  - bits [17:0] take `status_i[27:10]`;
  - bits [29:18] are zero.
- R4: On a return, `status_o[7]` (store-permission flag) is 1 when `status_i[9]` (retry flag) was 0. Otherwise it equals the shifted bit, `status_i[17]`.
- R5: On a return whose shifted status has bit 8 (user mode) set, that is `status_i[18]`=1, the next edge loads `ksp_o` with `sp_i` and `sp_o` with `usp_i`.
- R6: On a return without user mode, `sp_o` loads `sp_i`. In every cycle that is not a user-mode return, `ksp_o` keeps its value.
- R7: The next `store_fail_o` is `st_req_i` AND `status_i[7]`. This uses the status before any update, including in a return cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_i | input | 1 | Return-from-exception strobe |
| status_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | User stack pointer copy |
| st_req_i | input | 1 | Conditional-store request |
| status_o | output | 32 | Registered status word |
| sp_o | output | 32 | Registered stack pointer |
| ksp_o | output | 32 | Saved kernel stack pointer |
| store_fail_o | output | 1 | Conditional store refused |

## Verification
The kernel stack copy is the only state that persists across cycles. A wrong capture there appears on `ksp_o` one edge after the faulty return, and it stays visible until the next user-mode return.

The other outputs are recomputed on every edge, so a fault in the shift, the flag rule or the store gate appears on the very next edge. A store request issued in a return cycle separates the use of the old flag value from the use of the new one.

// File: rtl/exc_return_pkg.sv
package exc_return_pkg;

    localparam int unsigned WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] ksp;
        logic              fail;
    } ers_state_t;

endpackage

// File: rtl/ers_pop_unit.sv
module ers_pop_unit #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned KEEP_W    = 2,
    parameter int unsigned FIELD_W   = 28,
    parameter int unsigned POP_SHIFT = 10,
    parameter int unsigned P_BIT     = 7,
    parameter int unsigned R_BIT     = 9,
    parameter int unsigned U_BIT     = 8
) (
    input  logic [DATA_W-1:0] old_i,
    output logic [DATA_W-1:0] popped_o,
    output logic              user_o
);
    localparam int unsigned LOW_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK  = {{KEEP_W{1'b1}}, {LOW_W{1'b0}}};
    localparam logic [DATA_W-1:0] FIELD_MASK = {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

    logic [DATA_W-1:0] shifted;
    logic              retry_clear;

    always_comb begin
        shifted     = (old_i & KEEP_MASK) | ((old_i & FIELD_MASK) >> POP_SHIFT);
        retry_clear = ~old_i[R_BIT];
        popped_o    = shifted;
        if (retry_clear) begin
            popped_o[P_BIT] = 1'b1;
        end
        user_o = shifted[U_BIT];
    end
endmodule

// File: rtl/ers_stack_swap.sv
module ers_stack_swap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              swap_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] usp_i,
    input  logic [DATA_W-1:0] ksp_q_i,
    output logic [DATA_W-1:0] sp_d_o,
    output logic [DATA_W-1:0] ksp_d_o
);
    always_comb begin
        if (swap_i) begin
            sp_d_o  = usp_i;
            ksp_d_o = sp_i;
        end else begin
            sp_d_o  = sp_i;
            ksp_d_o = ksp_q_i;
        end
    end
endmodule

// File: rtl/ers_store_gate.sv
module ers_store_gate (
    input  logic req_i,
    input  logic perm_flag_i,
    output logic fail_o
);
    always_comb begin
        fail_o = req_i & perm_flag_i;
    end
endmodule

// File: rtl/exc_return_shifter.sv
module exc_return_shifter
    import exc_return_pkg::*;
#(
    parameter int unsigned KEEP_W    = 2,
    parameter int unsigned FIELD_W   = 28,
    parameter int unsigned POP_SHIFT = 10,
    parameter int unsigned P_BIT     = 7,
    parameter int unsigned R_BIT     = 9,
    parameter int unsigned U_BIT     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_i,
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] usp_i,
    input  logic              st_req_i,
    output logic [WORD_W-1:0] status_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] ksp_o,
    output logic              store_fail_o
);
    ers_state_t state_d, state_q;

    logic [WORD_W-1:0] popped;
    logic              popped_user;
    logic              swap_en;
    logic [WORD_W-1:0] sp_next;
    logic [WORD_W-1:0] ksp_next;
    logic              fail_next;

    ers_pop_unit #(
        .DATA_W   (WORD_W),
        .KEEP_W   (KEEP_W),
        .FIELD_W  (FIELD_W),
        .POP_SHIFT(POP_SHIFT),
        .P_BIT    (P_BIT),
        .R_BIT    (R_BIT),
        .U_BIT    (U_BIT)
    ) pop_i (
        .old_i   (status_i),
        .popped_o(popped),
        .user_o  (popped_user)
    );

    assign swap_en = ret_i & popped_user;

    ers_stack_swap #(
        .DATA_W(WORD_W)
    ) swap_i (
        .swap_i (swap_en),
        .sp_i   (sp_i),
        .usp_i  (usp_i),
        .ksp_q_i(state_q.ksp),
        .sp_d_o (sp_next),
        .ksp_d_o(ksp_next)
    );

    ers_store_gate gate_i (
        .req_i      (st_req_i),
        .perm_flag_i(status_i[P_BIT]),
        .fail_o     (fail_next)
    );

    always_comb begin
        state_d        = state_q;
        state_d.status = ret_i ? popped : status_i;
        state_d.sp     = sp_next;
        state_d.ksp    = ksp_next;
        state_d.fail   = fail_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o     = state_q.status;
    assign sp_o         = state_q.sp;
    assign ksp_o        = state_q.ksp;
    assign store_fail_o = state_q.fail;
endmodule

// File: rtl/exc_return_checker.sv
module exc_return_checker #(
    parameter int unsigned W         = 32,
    parameter int unsigned KEEP_W    = 2,
    parameter int unsigned FIELD_W   = 28,
    parameter int unsigned POP_SHIFT = 10,
    parameter int unsigned P_BIT     = 7,
    parameter int unsigned R_BIT     = 9,
    parameter int unsigned U_BIT     = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ret_i,
    input logic [W-1:0] status_i,
    input logic [W-1:0] sp_i,
    input logic [W-1:0] usp_i,
    input logic         st_req_i,
    input logic [W-1:0] status_o,
    input logic [W-1:0] sp_o,
    input logic [W-1:0] ksp_o,
    input logic         store_fail_o
);
    localparam int unsigned GAP_LO = FIELD_W - POP_SHIFT;
    localparam int unsigned GAP_HI = W - KEEP_W - 1;

    logic user_ret;
    assign user_ret = ret_i & status_i[U_BIT + POP_SHIFT];

    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_zero_r1: assert (status_o == '0 && sp_o == '0 && ksp_o == '0 && !store_fail_o);
        end
    end

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_i |=> (status_o == $past(status_i)) && (sp_o == $past(sp_i)));

    p_keep_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> status_o[W-1:W-KEEP_W] == $past(status_i[W-1:W-KEEP_W]));

    p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> status_o[GAP_HI:GAP_LO] == '0);

    p_perm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !status_i[R_BIT]) |=> status_o[P_BIT]);

    p_perm_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && status_i[R_BIT]) |=> status_o[P_BIT] == $past(status_i[P_BIT + POP_SHIFT]));

    p_user_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        user_ret |=> (ksp_o == $past(sp_i)) && (sp_o == $past(usp_i)));

    p_ksp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !user_ret |=> $stable(ksp_o));

    p_store_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> store_fail_o == $past(st_req_i && status_i[P_BIT]));
endmodule

bind exc_return_shifter exc_return_checker #(
    .W        (32),
    .KEEP_W   (KEEP_W),
    .FIELD_W  (FIELD_W),
    .POP_SHIFT(POP_SHIFT),
    .P_BIT    (P_BIT),
    .R_BIT    (R_BIT),
    .U_BIT    (U_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_i       (ret_i),
    .status_i    (status_i),
    .sp_i        (sp_i),
    .usp_i       (usp_i),
    .st_req_i    (st_req_i),
    .status_o    (status_o),
    .sp_o        (sp_o),
    .ksp_o       (ksp_o),
    .store_fail_o(store_fail_o)
);

// File: tb/exc_return_shifter_tb_top.sv
module exc_return_shifter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_i = 1'b0;
    logic [31:0] status_i = '0;
    logic [31:0] sp_i = '0;
    logic [31:0] usp_i = '0;
    logic        st_req_i = 1'b0;
    logic [31:0] status_o, sp_o, ksp_o;
    logic        store_fail_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] m_status = '0, m_sp = '0, m_ksp = '0;
    logic        m_fail = 1'b0;

    always #4 clk = ~clk;

    exc_return_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .ret_i(ret_i), .status_i(status_i),
        .sp_i(sp_i), .usp_i(usp_i), .st_req_i(st_req_i),
        .status_o(status_o), .sp_o(sp_o), .ksp_o(ksp_o),
        .store_fail_o(store_fail_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [31:0] st, input logic [31:0] sp,
                        input logic [31:0] usp, input logic req);
        logic [31:0] ns;
        ret_i = r; status_i = st; sp_i = sp; usp_i = usp; st_req_i = req;
        @(posedge clk);
        #1;
        m_fail = req && st[7];
        if (r) begin
            ns = (st & 32'hC000_0000) | ((st & 32'h0FFF_FFFF) >> 10);
            if (st[9] == 1'b0) ns[7] = 1'b1;
            if (ns[8]) begin
                m_ksp = sp;
                m_sp  = usp;
            end else begin
                m_sp = sp;
            end
            m_status = ns;
            chk("R3 status", status_o & ~32'h80, m_status & ~32'h80);
            chk("R4 perm flag", {31'b0, status_o[7]}, {31'b0, m_status[7]});
            chk(ns[8] ? "R5 sp" : "R6 sp", sp_o, m_sp);
            chk(ns[8] ? "R5 ksp" : "R6 ksp", ksp_o, m_ksp);
        end else begin
            m_status = st;
            m_sp = sp;
            chk("R2 status", status_o, m_status);
            chk("R2 sp", sp_o, m_sp);
            chk("R6 ksp hold", ksp_o, m_ksp);
        end
        chk("R7 store fail", {31'b0, store_fail_o}, {31'b0, m_fail});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status_o, '0);
        chk("R1 reset sp", sp_o, '0);
        chk("R1 reset ksp", ksp_o, '0);
        chk("R1 reset fail", {31'b0, store_fail_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // pass-through patterns
        step(0, 32'h1234_5678, 32'h0000_1000, 32'h0000_2000, 0);
        step(0, 32'hFFFF_FFFF, 32'hAAAA_5555, 32'h1111_1111, 1);
        step(0, 32'h0000_0080, 32'h0000_0004, 32'h0, 1);
        step(0, 32'h0000_0000, 32'h0000_0008, 32'h0, 1);
        // return, retry flag clear, kernel mode restored
        step(1, 32'hC000_0000, 32'h0000_3000, 32'h0000_4000, 0);
        // return, retry flag set, perm flag from shift = 0, user mode
        step(1, 32'h4004_0200, 32'h0000_5000, 32'h0000_6000, 0);
        // retry set, shifted perm flag = 1
        step(1, 32'h0002_0200, 32'h0000_7000, 32'h0000_8000, 0);
        // store in return cycle sees pre-return flag (clear, though new sets it)
        step(1, 32'h0000_0000, 32'h0000_9000, 32'h0000_A000, 1);
        // store in return cycle with pre-return flag set
        step(1, 32'h0FFF_FFFF, 32'h0000_B000, 32'h0000_C000, 1);
        // back-to-back user returns
        step(1, 32'h8004_0000, 32'h0000_D000, 32'h0000_E000, 0);
        step(1, 32'h8004_0300, 32'h0000_F000, 32'h0001_0000, 0);
        step(0, 32'h0000_0000, 32'h0002_0000, 32'h0003_0000, 0);
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 1), $urandom, $urandom, $urandom, $urandom_range(0, 1));
        end
        finish_run();
    end
endmodule